// File: doc/BRIEF.md
# Six-bit-opcode integer ALU

This block is the purely combinational arithmetic/logic unit of a small multi-cycle processor datapath. It takes two 32-bit operands and a 6-bit operation code and returns a 32-bit result together with a zero flag. The sequencer uses the flag to resolve conditional branches. For an equal or not-equal test it requests a subtraction and looks at whether the difference is zero. Stack pointer adjustment reuses the same adder, with the second operand forced to the constant 1.

The operation codes form a compact, non-standard set running from 1 to 9. The set includes a multiplier that returns the low half of the product. For the two shifts, the shift distance comes from the second operand. Every other code yields a zero result. The block has no carry or overflow output. Operand routing, immediate extension and register-file access belong to the surrounding datapath.

Top module: `alu6_core`

## Requirements
- R1: Opcode 0x01 returns opa + opb, modulo 2^32.
- R2: Opcode 0x02 returns opa - opb, modulo 2^32. With opb = 1 this is the decrement used for the stack pointer.
- R3: Opcode 0x03 returns the low 32 bits of the unsigned product opa * opb.
- R4: Opcode 0x04 shifts opa right by the shift distance and fills the vacated high bits with zeros.
- R5: Opcode 0x05 shifts opa left by the shift distance and fills the vacated low bits with zeros.
- R6: Opcode 0x06 returns the bitwise AND of the operands, 0x07 the bitwise OR, and 0x08 the bitwise NOR.
- R7: Opcode 0x09 compares the operands as signed two's-complement values. Bit 0 of the result is 1 when opa < opb and 0 otherwise. Bits 31:1 are always 0.
- R8: Opcode 0x00 and every opcode from 0x0A to 0x3F give a result of all zeros, whatever the operands.
- R9: zero is 1 exactly when all 32 result bits are 0, for every opcode, including the undefined ones.
- R10: The shift distance is opb[4:0]. Bits 31:5 of opb have no effect on either shift, so opb = 32 shifts by 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Operation code |
| opa_i | input | 32 | First operand; the value that is shifted |
| opb_i | input | 32 | Second operand; its low 5 bits give the shift distance |
| result_o | output | 32 | Result of the selected operation |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The block holds no state, so any fault appears at the ports combinationally, in the same cycle the operands and code are applied. A wrong decode shows up as a result belonging to another operation, or as a non-zero value for an undefined code. A broken shift stage corrupts only the results whose shift distance has that bit set. Random distances and directed distances of 0, 31 and 32 therefore cover each stage. A fault in the shared subtractor affects both the difference and set-less-than. Operand pairs with mixed signs separate the signed comparison from an unsigned one, and the zero flag is compared on every vector.

// File: rtl/alu6_pkg.sv
package alu6_pkg;

  localparam int OPC_W = 6;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD  = 6'h01,
    OPC_SUB  = 6'h02,
    OPC_MUL  = 6'h03,
    OPC_SHR  = 6'h04,
    OPC_SHL  = 6'h05,
    OPC_AND  = 6'h06,
    OPC_OR   = 6'h07,
    OPC_NOR  = 6'h08,
    OPC_SLT  = 6'h09
  } alu_opc_e;

endpackage

// File: rtl/alu6_arith.sv
module alu6_arith #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W-1:0] prod_o
);

  logic [DATA_W-1:0] b_inv;

  // one adder serves add, subtract and the signed compare
  assign b_inv  = b_i ^ {DATA_W{sub_i}};
  assign sum_o  = a_i + b_inv + {{(DATA_W-1){1'b0}}, sub_i};
  assign prod_o = a_i * b_i;

endmodule

// File: rtl/alu6_shift.sv
module alu6_shift #(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [SH_W-1:0]   amt_i,
  output logic [DATA_W-1:0] shr_o,
  output logic [DATA_W-1:0] shl_o
);

  logic [DATA_W-1:0] rstage [SH_W+1];
  logic [DATA_W-1:0] lstage [SH_W+1];

  assign rstage[0] = a_i;
  assign lstage[0] = a_i;

  // logarithmic barrel: stage s moves by 2**s when amt_i[s] is set
  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    assign rstage[s+1] = amt_i[s] ? (rstage[s] >> (2**s)) : rstage[s];
    assign lstage[s+1] = amt_i[s] ? (lstage[s] << (2**s)) : lstage[s];
  end

  assign shr_o = rstage[SH_W];
  assign shl_o = lstage[SH_W];

endmodule

// File: rtl/alu6_logic.sv
module alu6_logic #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              diff_msb_i,
  output logic [DATA_W-1:0] and_o,
  output logic [DATA_W-1:0] or_o,
  output logic [DATA_W-1:0] nor_o,
  output logic [DATA_W-1:0] slt_o
);

  logic sign_differs;
  logic less;

  assign and_o = a_i & b_i;
  assign or_o  = a_i | b_i;
  assign nor_o = ~(a_i | b_i);

  // signs differ: the negative operand is smaller; otherwise the
  // difference cannot overflow and its sign decides
  assign sign_differs = a_i[DATA_W-1] ^ b_i[DATA_W-1];
  assign less         = sign_differs ? a_i[DATA_W-1] : diff_msb_i;
  assign slt_o        = {{(DATA_W-1){1'b0}}, less};

endmodule

// File: rtl/alu6_zero_detect.sv
module alu6_zero_detect #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] val_i,
  output logic              zero_o
);

  assign zero_o = ~|val_i;

endmodule

// File: rtl/alu6_core.sv
module alu6_core #(
  parameter int DATA_W = 32,
  localparam int OPC_W = alu6_pkg::OPC_W,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [OPC_W-1:0]  op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o
);
  import alu6_pkg::*;

  logic              use_sub;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] prod;
  logic [DATA_W-1:0] shr;
  logic [DATA_W-1:0] shl;
  logic [DATA_W-1:0] and_v;
  logic [DATA_W-1:0] or_v;
  logic [DATA_W-1:0] nor_v;
  logic [DATA_W-1:0] slt_v;
  logic [DATA_W-1:0] res_sel;

  assign use_sub = (op_i == OPC_SUB) || (op_i == OPC_SLT);

  alu6_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .sub_i  (use_sub),
    .sum_o  (sum),
    .prod_o (prod)
  );

  alu6_shift #(.DATA_W(DATA_W)) u_shift (
    .a_i   (opa_i),
    .amt_i (opb_i[SH_W-1:0]),
    .shr_o (shr),
    .shl_o (shl)
  );

  alu6_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i        (opa_i),
    .b_i        (opb_i),
    .diff_msb_i (sum[DATA_W-1]),
    .and_o      (and_v),
    .or_o       (or_v),
    .nor_o      (nor_v),
    .slt_o      (slt_v)
  );

  always_comb begin
    res_sel = '0;
    case (op_i)
      OPC_ADD,
      OPC_SUB: res_sel = sum;
      OPC_MUL: res_sel = prod;
      OPC_SHR: res_sel = shr;
      OPC_SHL: res_sel = shl;
      OPC_AND: res_sel = and_v;
      OPC_OR:  res_sel = or_v;
      OPC_NOR: res_sel = nor_v;
      OPC_SLT: res_sel = slt_v;
      default: res_sel = '0;
    endcase
  end

  assign result_o = res_sel;

  alu6_zero_detect #(.DATA_W(DATA_W)) u_zero (
    .val_i  (res_sel),
    .zero_o (zero_o)
  );

endmodule

// File: rtl/alu6_core_chk.sv
module alu6_core_chk #(
  parameter int DATA_W = 32,
  localparam int OPC_W = alu6_pkg::OPC_W,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input logic [OPC_W-1:0]  op_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic [DATA_W-1:0] result_o,
  input logic              zero_o
);

  logic [DATA_W-1:0] low_mask;
  assign low_mask = ({{(DATA_W-1){1'b0}}, 1'b1} << opb_i[SH_W-1:0]) - 1'b1;

  always_comb begin
    // R2
    sub_zero_chk: assert (!(op_i == 6'h02 && opb_i == '0) || result_o == opa_i)
      else $error("subtract of zero changed operand");
    // R5
    shl_fill_chk: assert (op_i != 6'h05 || (result_o & low_mask) == '0)
      else $error("left shift left ones in low bits");
    // R6
    and_subset_chk: assert (op_i != 6'h06 || (result_o & ~opa_i) == '0)
      else $error("AND set a bit absent from opa");
    // R6
    or_cover_chk: assert (op_i != 6'h07 || (opa_i & ~result_o) == '0)
      else $error("OR lost a bit of opa");
    // R6
    nor_disjoint_chk: assert (op_i != 6'h08 || (result_o & opb_i) == '0)
      else $error("NOR kept a bit of opb");
    // R7
    slt_upper_chk: assert (op_i != 6'h09 || result_o[DATA_W-1:1] == '0)
      else $error("compare set upper bits");
    // R8
    undef_zero_chk: assert (!(op_i == 6'h00 || op_i > 6'h09) || (result_o == '0 && zero_o))
      else $error("undefined code gave a value");
    // R9
    zero_flag_chk: assert (zero_o == (result_o == '0))
      else $error("zero flag disagrees with result");
  end

endmodule

bind alu6_core alu6_core_chk #(.DATA_W(DATA_W)) u_alu6_core_chk (
  .op_i     (op_i),
  .opa_i    (opa_i),
  .opb_i    (opb_i),
  .result_o (result_o),
  .zero_o   (zero_o)
);

// File: tb/alu6_core_bench.sv
`timescale 1ns/1ps
module alu6_core_bench;

  logic        clk;
  logic        rst_n;
  logic [5:0]  op;
  logic [31:0] opa;
  logic [31:0] opb;
  logic [31:0] result;
  logic        zero;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  alu6_core u_alu6_core (
    .op_i     (op),
    .opa_i    (opa),
    .opb_i    (opb),
    .result_o (result),
    .zero_o   (zero)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] ref_result(logic [5:0] o, logic [31:0] a, logic [31:0] b);
    logic [63:0] p;
    case (o)
      6'h01: return a + b;
      6'h02: return a - b;
      6'h03: begin p = {32'd0, a} * {32'd0, b}; return p[31:0]; end
      6'h04: return a >> b[4:0];
      6'h05: return a << b[4:0];
      6'h06: return a & b;
      6'h07: return a | b;
      6'h08: return ~(a | b);
      6'h09: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [5:0] o);
    case (o)
      6'h01: return "R1";
      6'h02: return "R2";
      6'h03: return "R3";
      6'h04: return "R4";
      6'h05: return "R5";
      6'h06, 6'h07, 6'h08: return "R6";
      6'h09: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input logic [5:0] o, input logic [31:0] a, input logic [31:0] b,
                       input string tag);
    logic [31:0] exp_r;
    @(posedge clk);
    #0.5;
    op = o; opa = a; opb = b;
    exp_r = ref_result(o, a, b);
    @(negedge clk);
    n_checks++;
    if (result !== exp_r) begin
      n_fail++;
      $display("FAIL %s op=%02h a=%08h b=%08h result actual=%08h expected=%08h",
               tag, o, a, b, result, exp_r);
    end
    n_checks++;
    if (zero !== (exp_r == 32'd0)) begin
      n_fail++;
      $display("FAIL R9 op=%02h a=%08h b=%08h zero actual=%0b expected=%0b",
               o, a, b, zero, (exp_r == 32'd0));
    end
  endtask

  initial begin
    #20000000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20517));
    rst_n = 1'b0;
    op = 6'h00; opa = '0; opb = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // quiet state: undefined code 0x00 with zero operands (R8, R9)
    apply(6'h00, 32'd0, 32'd0, "R8");
    // R1 wrap-around
    apply(6'h01, 32'hFFFF_FFFF, 32'd1, "R1");
    apply(6'h01, 32'h7FFF_FFFF, 32'd1, "R1");
    // R2 decrement, equality test, borrow
    apply(6'h02, 32'h0000_1000, 32'd1, "R2");
    apply(6'h02, 32'h1234_5678, 32'h1234_5678, "R2");
    apply(6'h02, 32'd0, 32'd1, "R2");
    // R3 low half of product
    apply(6'h03, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
    apply(6'h03, 32'h0001_0000, 32'h0001_0000, "R3");
    // R4 / R5 distance extremes
    apply(6'h04, 32'h8000_0000, 32'd31, "R4");
    apply(6'h04, 32'hF0F0_F0F0, 32'd0, "R4");
    apply(6'h05, 32'h0000_0001, 32'd31, "R5");
    apply(6'h05, 32'hFFFF_FFFF, 32'd16, "R5");
    // R10 upper bits of opb ignored for shifts
    apply(6'h04, 32'hDEAD_BEEF, 32'd32, "R10");
    apply(6'h05, 32'hDEAD_BEEF, 32'hFFFF_FFE3, "R10");
    apply(6'h04, 32'hDEAD_BEEF, 32'h8000_0004, "R10");
    // R6 logic
    apply(6'h06, 32'hF0F0_F0F0, 32'h0F0F_0F0F, "R6");
    apply(6'h07, 32'hF0F0_F0F0, 32'h0F0F_0F0F, "R6");
    apply(6'h08, 32'hF0F0_F0F0, 32'h0F0F_0F0F, "R6");
    apply(6'h08, 32'd0, 32'd0, "R6");
    // R7 signed compare, mixed signs and overflow-prone pairs
    apply(6'h09, 32'hFFFF_FFFF, 32'd1, "R7");
    apply(6'h09, 32'd1, 32'hFFFF_FFFF, "R7");
    apply(6'h09, 32'h8000_0000, 32'h7FFF_FFFF, "R7");
    apply(6'h09, 32'h7FFF_FFFF, 32'h8000_0000, "R7");
    apply(6'h09, 32'd5, 32'd5, "R7");
    // R8 undefined codes with busy operands
    apply(6'h0A, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8");
    apply(6'h3F, 32'h1234_5678, 32'h9ABC_DEF0, "R8");
    apply(6'h20, 32'h0000_0001, 32'h0000_0002, "R8");

    // constrained random: codes 0..15 and mixed operand sizes
    for (int i = 0; i < 3000; i++) begin
      logic [5:0]  ro;
      logic [31:0] ra;
      logic [31:0] rb;
      ro = 6'($urandom % 16);
      if (($urandom % 8) == 0) ro = 6'($urandom % 64);
      ra = $urandom;
      rb = $urandom;
      case ($urandom % 4)
        0: rb = rb & 32'h0000_003F;
        1: ra = ra & 32'h0000_00FF;
        2: rb = ra;
        default: ;
      endcase
      apply(ro, ra, rb, tag_of(ro));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule